// File: doc/BRIEF.md
# PDM Idle-Pattern Standby Detector

This block sits on a one-bit pulse-density-modulated audio input and decides when the stream has gone idle. The upstream source signals idle by sending one fixed 8-bit pattern over and over. When the detector has seen that pattern continuously for a long enough run, and the automatic power-down feature is turned on, it raises a standby flag. The power controller uses that flag to shut down the output stage and, if it chooses, stop the bit clock. The first bit that breaks the pattern lowers the flag again and produces a single-cycle wake pulse.

The data bit is synchronous to the bit clock, with one bit per clock, so it is sampled directly. The detector does not need the pattern to start on a byte boundary. It keeps the last eight bits and counts how many bits in a row have repeated the bit from eight clocks earlier while the eight-bit window holds some rotation of the pattern. The run count is available as a status output.

Top module: `pdm_idle_detector`

## Requirements
- R1: While reset is asserted, and right after it, `standby` is 0, `wake_pulse` is 0 and `run_count` is 0. The bit history is also cleared to all zeros.
- R2: While `spd_enable` is 1, `run_count` goes up by one at each clock edge that meets both of these conditions. First, the incoming bit equals the bit received eight clocks earlier. Second, the newest eight bits (oldest first) form a cyclic rotation of the idle byte 0xAC, whose bits are sent MSB first as 1,0,1,0,1,1,0,0. The starting phase within the byte does not matter.
- R3: A bit that fails either condition in R2 sets `run_count` to 0 at that clock edge.
- R4: `run_count` saturates at 1024, which is 128 repetitions of 8 bits. It never exceeds 1024 and never wraps.
- R5: `standby` rises at the same edge where `run_count` first reaches 1024. It is 0 while the count is 1023 or less.
- R6: While in standby with `spd_enable` at 1, a breaking bit clears `standby` at that edge. At the same edge `wake_pulse` is 1 for exactly one cycle.
- R7: While `spd_enable` is 0, `run_count` is 0 and `standby` is 0 after every edge, whatever the data.
- R8: Driving `spd_enable` low while in standby clears `standby` and `run_count` at the next edge. No `wake_pulse` is produced.
- R9: `wake_pulse` is 1 only in the cycle right after standby was left because of a breaking bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PDM bit clock |
| rst_n | input | 1 | Asynchronous active-low reset. Its release is synchronized inside the block. |
| pdm_bit | input | 1 | PDM data bit, synchronous to `clk` |
| spd_enable | input | 1 | Enables automatic idle detection and standby entry |
| standby | output | 1 | Standby request |
| wake_pulse | output | 1 | One-cycle pulse marking exit from standby on a pattern break |
| run_count | output | 11 | Saturating count of consecutive matching bits |

## Verification
The assertions assume that `spd_enable` and `pdm_bit` change only between clock edges and never during the first cycles after reset release. The bench holds both inputs at 0 for several cycles after reset and changes them only on falling edges. The stream mixes several things:
- whole pattern runs started at different byte phases;
- runs broken just before the threshold;
- runs kept going past the threshold into saturation;
- enable drops in and out of standby;
- pseudo-random bits with sparse pattern breaks.

This mix makes every rule on count, standby and wake occur under legal input timing.

// File: rtl/pdm_idle_pkg.sv
package pdm_idle_pkg;

  // Width of the idle pattern in bits
  localparam int unsigned PAT_W_DEF    = 8;
  // Idle byte, transmitted MSB first
  localparam logic [7:0]  PATTERN_DEF  = 8'hAC;
  // Number of pattern repetitions needed for standby
  localparam int unsigned MIN_REPS_DEF = 128;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'b00,
    ST_STANDBY = 2'b01
  } pwr_state_e;

endpackage

// File: rtl/pdm_rst_sync.sv
module pdm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_int_n = sync_q[STAGES-1];

endmodule

// File: rtl/pdm_bit_history.sv
module pdm_bit_history #(
  parameter int unsigned PAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [PAT_W-1:0] window_next,
  output logic             repeat_ok
);

  logic [PAT_W-1:0] hist_q;
  logic [PAT_W-1:0] hist_d;

  // Newest bit enters at the LSB; MSB holds the bit from PAT_W clocks ago
  always_comb begin
    hist_d      = {hist_q[PAT_W-2:0], bit_in};
    window_next = hist_d;
    repeat_ok   = (bit_in == hist_q[PAT_W-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
    end else begin
      hist_q <= hist_d;
    end
  end

endmodule

// File: rtl/pdm_rot_match.sv
module pdm_rot_match #(
  parameter int unsigned     PAT_W   = 8,
  parameter logic [PAT_W-1:0] PATTERN = 8'hAC
) (
  input  logic [PAT_W-1:0] window,
  output logic             is_rotation
);

  localparam logic [2*PAT_W-1:0] DOUBLED = {PATTERN, PATTERN};

  logic [PAT_W-1:0] hit_vec;

  generate
    for (genvar r = 0; r < PAT_W; r++) begin : g_rot
      localparam logic [PAT_W-1:0] ROT = DOUBLED[2*PAT_W-1-r -: PAT_W];
      assign hit_vec[r] = (window == ROT);
    end
  endgenerate

  assign is_rotation = |hit_vec;

endmodule

// File: rtl/pdm_run_counter.sv
module pdm_run_counter #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned THRESH = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             hit_next
);

  localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(THRESH);
  localparam logic [CNT_W-1:0] PRELIMIT = CNT_W'(THRESH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (!inc) begin
      cnt_d = '0;
    end else if (cnt_q >= LIMIT) begin
      cnt_d = LIMIT;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    hit_next = inc && (cnt_q >= PRELIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/pdm_idle_detector.sv
module pdm_idle_detector
  import pdm_idle_pkg::*;
#(
  parameter int unsigned      PAT_W    = PAT_W_DEF,
  parameter logic [PAT_W-1:0] PATTERN  = PATTERN_DEF,
  parameter int unsigned      MIN_REPS = MIN_REPS_DEF,
  localparam int unsigned     THRESH   = PAT_W * MIN_REPS,
  localparam int unsigned     CNT_W    = $clog2(THRESH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pdm_bit,
  input  logic             spd_enable,
  output logic             standby,
  output logic             wake_pulse,
  output logic [CNT_W-1:0] run_count
);

  logic             rst_int_n;
  logic [PAT_W-1:0] window_next;
  logic             repeat_ok;
  logic             is_rot;
  logic             bit_match;
  logic             hit_next;

  pwr_state_e state_q, state_d;
  logic       wake_q, wake_d;

  pdm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pdm_bit_history #(.PAT_W(PAT_W)) u_hist (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .bit_in      (pdm_bit),
    .window_next (window_next),
    .repeat_ok   (repeat_ok)
  );

  pdm_rot_match #(.PAT_W(PAT_W), .PATTERN(PATTERN)) u_match (
    .window      (window_next),
    .is_rotation (is_rot)
  );

  // A bit extends the run only when enabled, repeating, and inside a rotation
  assign bit_match = spd_enable && repeat_ok && is_rot;

  pdm_run_counter #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .inc      (bit_match),
    .count    (run_count),
    .hit_next (hit_next)
  );

  // Next-state logic for the power state and the wake pulse
  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_ACTIVE: begin
        if (hit_next) begin
          state_d = ST_STANDBY;
        end
      end
      ST_STANDBY: begin
        if (!spd_enable) begin
          state_d = ST_ACTIVE;
        end else if (!bit_match) begin
          state_d = ST_ACTIVE;
          wake_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_ACTIVE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_ACTIVE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign standby    = (state_q == ST_STANDBY);
  assign wake_pulse = wake_q;

endmodule

// File: rtl/pdm_idle_checker.sv
module pdm_idle_checker #(
  parameter int unsigned CNT_W  = 11,
  parameter int unsigned THRESH = 1024
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spd_enable,
  input logic             standby,
  input logic             wake_pulse,
  input logic [CNT_W-1:0] run_count
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(THRESH);

  // R4
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_count <= LIMIT);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_count != '0) |-> ((run_count == $past(run_count) + 1'b1) ||
                           ((run_count == LIMIT) && ($past(run_count) == LIMIT))));

  // R5
  standby_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> (run_count == LIMIT));

  // R6
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (!standby && $past(standby)));

  // R9
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spd_enable |=> (run_count == '0 && !standby));

  // R8
  disable_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !spd_enable) |=> (!standby && !wake_pulse));

endmodule

bind pdm_idle_detector pdm_idle_checker #(
  .CNT_W  (CNT_W),
  .THRESH (THRESH)
) u_idle_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spd_enable (spd_enable),
  .standby    (standby),
  .wake_pulse (wake_pulse),
  .run_count  (run_count)
);

// File: tb/tb_pdm_idle_detector.sv
`timescale 1ns/1ps
module tb_pdm_idle_detector;

  localparam int THRESH = 1024;
  localparam int PAT    = 8'hAC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pdm_bit = 1'b0;
  logic        spd_enable = 1'b0;
  logic        standby;
  logic        wake_pulse;
  logic [10:0] run_count;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit model_on = 1'b0;

  // Reference model state
  bit hist[$];
  int exp_cnt = 0;
  bit exp_stby = 1'b0;
  bit exp_wake = 1'b0;
  int prev_dut_cnt = 0;
  bit prev_dut_stby = 1'b0;
  bit seen_standby = 1'b0;
  bit seen_wake = 1'b0;
  bit seen_sat = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  pdm_idle_detector dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pdm_bit    (pdm_bit),
    .spd_enable (spd_enable),
    .standby    (standby),
    .wake_pulse (wake_pulse),
    .run_count  (run_count)
  );

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  function automatic bit is_rot(input int w);
    for (int r = 0; r < 8; r++) begin
      int rot;
      rot = ((PAT << r) | (PAT >> (8 - r))) & 255;
      if (rot == w) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i < 8; i++) hist.push_back(1'b0);
    exp_cnt  = 0;
    exp_stby = 1'b0;
    exp_wake = 1'b0;
  endtask

  // Behavioural reference, updated at every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      model_reset();
    end else if (model_on) begin
      int win;
      bit ok;
      bit was_stby;
      win = 0;
      for (int i = 1; i < 8; i++) win = (win << 1) | int'(hist[i]);
      win = (win << 1) | int'(pdm_bit);
      ok = spd_enable && (pdm_bit == hist[0]) && is_rot(win);
      was_stby = exp_stby;
      if (ok) exp_cnt = (exp_cnt >= THRESH) ? THRESH : exp_cnt + 1;
      else exp_cnt = 0;
      exp_stby = spd_enable && (exp_cnt == THRESH);
      exp_wake = was_stby && spd_enable && !ok;
      void'(hist.pop_front());
      hist.push_back(pdm_bit);
    end
  end

  // Compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check("R2/R3/R4 run_count", int'(run_count), exp_cnt);
      check("R5/R8 standby", int'(standby), int'(exp_stby));
      check("R6/R9 wake_pulse", int'(wake_pulse), int'(exp_wake));
      if (standby && !prev_dut_stby) begin
        // R5: entry exactly when count reaches the threshold from 1023
        check("R5 count at entry", int'(run_count), THRESH);
        check("R5 count before entry", prev_dut_cnt, THRESH - 1);
        seen_standby = 1'b1;
      end
      if (wake_pulse) seen_wake = 1'b1;
      if (standby && prev_dut_stby && int'(run_count) == THRESH && prev_dut_cnt == THRESH)
        seen_sat = 1'b1;
      prev_dut_cnt  = int'(run_count);
      prev_dut_stby = standby;
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send_bit(input bit b);
    @(negedge clk);
    pdm_bit = b;
  endtask

  task automatic send_pattern(input int nbits, input int phase);
    for (int i = 0; i < nbits; i++) begin
      int pos;
      pos = (phase + i) % 8;
      send_bit(PAT[7 - pos]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    spd_enable = 1'b0;
    pdm_bit = 1'b0;
    @(posedge clk);
    #1;
    // R1: outputs cleared while reset is held
    check("R1 standby in reset", int'(standby), 0);
    check("R1 wake in reset", int'(wake_pulse), 0);
    check("R1 count in reset", int'(run_count), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 count after reset", int'(run_count), 0);
    check("R1 standby after reset", int'(standby), 0);
  endtask

  initial begin
    model_reset();
    do_reset();
    model_on = 1'b1;

    // R7: pattern with the feature off never counts
    spd_enable = 1'b0;
    send_pattern(1200, 0);
    @(negedge clk);
    check("R7 count disabled", int'(run_count), 0);
    check("R7 standby disabled", int'(standby), 0);

    // R2/R4/R5: unaligned pattern run into standby and saturation
    spd_enable = 1'b1;
    send_pattern(1100, 3);
    @(negedge clk);
    check("R4 saturated count", int'(run_count), THRESH);
    check("R5 standby held", int'(standby), 1);

    // R6: one breaking bit wakes the block
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    check("R6 left standby", int'(standby), 0);

    // R3: run broken just short of the threshold, then restarted
    send_pattern(1020, 5);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    check("R3 count cleared", int'(run_count), 0);
    send_pattern(1060, 1);
    check("R5 standby after restart", int'(standby), 1);

    // R8: dropping enable in standby exits without a wake pulse
    @(negedge clk);
    spd_enable = 1'b0;
    send_pattern(4, 1);
    check("R8 standby cleared", int'(standby), 0);
    check("R8 count cleared", int'(run_count), 0);

    // Mixed stream: pattern with sparse pseudo-random breaks and enable toggles
    begin
      logic [15:0] lfsr;
      lfsr = 16'hACE1;
      for (int blk = 0; blk < 12; blk++) begin
        spd_enable = (blk % 4) != 3;
        for (int i = 0; i < 900; i++) begin
          bit b;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          b = PAT[7 - ((i + blk) % 8)];
          if (lfsr[7:0] == 8'h00 && blk > 5) b = ~b;
          send_bit(b);
        end
      end
    end

    // Reset after activity clears everything (R1)
    do_reset();
    model_reset();

    check("R5 standby was reached", int'(seen_standby), 1);
    check("R6 wake pulse was seen", int'(seen_wake), 1);
    check("R4 saturation was seen", int'(seen_sat), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule